// File: doc/BRIEF.md
# Register-driven SPI flash command engine

This block runs single SPI flash transactions that software describes through a small byte-addressed register bus. Software fills in an opcode, an address of 0 to 4 bytes, a count of dummy clocks, a chip-select choice, a data direction and a byte count. It then writes the start bit. The engine drives the opcode, address and dummy clocks on one data line in SPI mode 0. Next it either sends bytes from a 64-byte data window or fills that window with bytes read from the flash. A busy flag stays up until chip select is released.

The engine comes out of reset in automatic mode and ignores start requests there. Software can drop the two mode-control bits to enter manual mode only after an unlock pair. The pair is 0x55 followed by 0xAA, written to the opcode register on consecutive bus writes. While a transaction runs, the register file is frozen and every bus write is discarded.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the control byte reads 0x30, meaning automatic mode with busy and direction clear. Configuration, opcode, count and address read 0. Both chip selects are high and SCLK is low.
- R2: Registers sit at these offsets: a 32-bit configuration word at 0x00-0x03, control at 0x04, opcode at 0x05, byte count at 0x06, and a 32-bit address at 0x08-0x0B. Both 32-bit words store byte 0 as the least significant byte. The data window is at 0x40-0x7F. Stored values read back, and unmapped offsets read 0.
- R3: A control write with bit 0 set, made while manual mode (control bits 5:4 both 0) is already in effect and the engine is idle, launches a transaction. Control bit 1 (busy) reads 1 from the next cycle until chip select rises. Bit 0 always reads 0.
- R4: The serial stream is the opcode, MSB first, then the low A bytes of the address, most significant byte first, then D dummy clocks with MOSI low, then data. A is config bits 18:16, with values above 4 taken as 4. D is config bits 23:19. There are exactly 8+8A+D+8N SCLK pulses, where N is the effective byte count.
- R5: SCLK idles low, runs at HALF_DIV system clocks per half period, and MOSI changes only while SCLK is low.
- R6: Config bit 24 selects which chip select is driven low: 0 selects cs_n_o[0] and 1 selects cs_n_o[1]. The other stays high. The first rising SCLK edge comes 3*HALF_DIV clocks after the fall, and chip select rises 2*HALF_DIV clocks after the last falling SCLK edge.
- R7: With control bit 3 set (send), N bytes go out from window offsets 0 to N-1 in order. N is the count register, with values above 64 taken as 64. A count of 0 gives no data phase.
- R8: With control bit 3 clear (receive), MISO is sampled on rising SCLK edges during the data phase and stored MSB first into window offsets 0 to N-1.
- R9: While busy, every bus write is ignored, a second start included: registers and window keep their values and no second transaction follows.
- R10: A start written while bits 5:4 are not both 0 (automatic mode) does nothing: no chip select activity and busy stays 0.
- R11: A control write may clear bits of 5:4 only when the two writes just before it were 0x55 and then 0xAA to offset 0x05. Any other write in between cancels the unlock. Setting bits of 5:4 is always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 7 | Byte offset for read and write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| cs_n_o | output | 2 | Chip selects, active low |

## Verification
The hardest situation to reach is a bus write that lands in the middle of a running transaction. This covers a repeated start, an opcode rewrite, a window write and a configuration write. A directed send transaction pushes all four through the bus while busy is high. The bench then checks that exactly one chip-select cycle occurred, that the stream matched the original setup, and that the registers read back unchanged. The unlock rule also needs deliberate ordering: the stimulus puts an unrelated write between 0x55 and 0xAA, sets a single mode bit, and then attempts to clear it with and without the unlock pair.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned BUF_BYTES = 64;
  localparam int unsigned NUM_CS    = 2;
  localparam int unsigned MAX_ABYTES = 4;

  localparam logic [6:0] OFS_CTRL = 7'h04;
  localparam logic [6:0] OFS_OPC  = 7'h05;
  localparam logic [6:0] OFS_CNT  = 7'h06;

  localparam logic [7:0] UNLOCK_A = 8'h55;
  localparam logic [7:0] UNLOCK_B = 8'hAA;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_SHIFT, SQ_TRAIL} seq_state_e;
  typedef enum logic [1:0] {UNL_IDLE, UNL_HALF, UNL_ARMED} unl_state_e;
endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [6:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       busy_i,
  output logic       start_o,
  output logic [7:0] opcode_o,
  output logic [31:0] address_o,
  output logic [2:0] abytes_o,
  output logic [4:0] dummy_o,
  output logic [6:0] count_o,
  output logic       dir_tx_o,
  output logic       cs_sel_o,
  input  logic [5:0] tx_idx_i,
  output logic [7:0] tx_byte_o,
  input  logic       cap_we_i,
  input  logic [5:0] cap_idx_i,
  input  logic [2:0] cap_bit_i,
  input  logic       cap_val_i
);
  logic [31:0] cfg_q, adr_q;
  logic [7:0]  opc_q, cnt_q;
  logic        dir_q;
  logic [1:0]  auto_q;
  unl_state_e  unl_q;
  logic [7:0]  buf_q [BUF_BYTES];

  logic wr_ok;
  assign wr_ok = wr_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      adr_q  <= '0;
      opc_q  <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      auto_q <= 2'b11;
      unl_q  <= UNL_IDLE;
    end else if (wr_ok) begin
      if (addr_i[6:2] == 5'd0) cfg_q[{addr_i[1:0], 3'b000} +: 8] <= wdata_i;
      if (addr_i[6:2] == 5'd2) adr_q[{addr_i[1:0], 3'b000} +: 8] <= wdata_i;
      if (addr_i == OFS_OPC)   opc_q <= wdata_i;
      if (addr_i == OFS_CNT)   cnt_q <= wdata_i;
      if (addr_i == OFS_CTRL) begin
        dir_q  <= wdata_i[3];
        // clearing mode bits needs the unlock pair; setting is free
        auto_q <= (unl_q == UNL_ARMED) ? wdata_i[5:4] : (auto_q | wdata_i[5:4]);
      end
      if (addr_i == OFS_OPC && wdata_i == UNLOCK_A)
        unl_q <= UNL_HALF;
      else if (addr_i == OFS_OPC && wdata_i == UNLOCK_B && unl_q == UNL_HALF)
        unl_q <= UNL_ARMED;
      else
        unl_q <= UNL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else begin
      if (wr_ok && addr_i[6]) buf_q[addr_i[5:0]] <= wdata_i;
      if (cap_we_i)           buf_q[cap_idx_i][cap_bit_i] <= cap_val_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[6])                rdata_o = buf_q[addr_i[5:0]];
    else if (addr_i[6:2] == 5'd0) rdata_o = cfg_q[{addr_i[1:0], 3'b000} +: 8];
    else if (addr_i[6:2] == 5'd2) rdata_o = adr_q[{addr_i[1:0], 3'b000} +: 8];
    else if (addr_i == OFS_CTRL)  rdata_o = {2'b00, auto_q, dir_q, 1'b0, busy_i, 1'b0};
    else if (addr_i == OFS_OPC)   rdata_o = opc_q;
    else if (addr_i == OFS_CNT)   rdata_o = cnt_q;
  end

  assign start_o   = wr_ok && (addr_i == OFS_CTRL) && wdata_i[0] && (auto_q == 2'b00);
  assign opcode_o  = opc_q;
  assign address_o = adr_q;
  assign abytes_o  = cfg_q[18:16];
  assign dummy_o   = cfg_q[23:19];
  assign cs_sel_o  = cfg_q[24];
  assign dir_tx_o  = dir_q;
  assign count_o   = (cnt_q > 8'(BUF_BYTES)) ? 7'(BUF_BYTES) : cnt_q[6:0];
  assign tx_byte_o = buf_q[tx_idx_i];
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        start_i,
  input  logic [7:0]  opcode_i,
  input  logic [31:0] address_i,
  input  logic [2:0]  abytes_i,
  input  logic [4:0]  dummy_i,
  input  logic [6:0]  count_i,
  input  logic        dir_tx_i,
  input  logic        cs_sel_i,
  input  logic [7:0]  tx_byte_i,
  input  logic        miso_i,
  output logic        busy_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [5:0]  tx_idx_o,
  output logic        cap_we_o,
  output logic [5:0]  cap_idx_o,
  output logic [2:0]  cap_bit_o,
  output logic        cap_val_o
);
  seq_state_e  st_q;
  logic        ph_q, sclk_q;
  logic [9:0]  k_q;
  logic [2:0]  ab;
  logic [9:0]  addr_end, dum_end, total;
  logic [8:0]  dk;
  logic [4:0]  aidx;
  logic        in_data;

  assign ab       = (abytes_i > 3'(MAX_ABYTES)) ? 3'(MAX_ABYTES) : abytes_i;
  assign addr_end = 10'd8 + {4'd0, ab, 3'b000};
  assign dum_end  = addr_end + {5'd0, dummy_i};
  assign total    = dum_end + {count_i, 3'b000};
  assign in_data  = (k_q >= dum_end);
  assign dk       = 9'(k_q - dum_end);
  assign aidx     = 5'({ab, 3'b000} - 6'd1 - 6'(k_q - 10'd8));
  assign tx_idx_o = dk[8:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE; ph_q <= 1'b0; sclk_q <= 1'b0; k_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q <= SQ_LEAD; ph_q <= 1'b0; k_q <= '0;
        end
        SQ_LEAD: if (tick_i) begin
          ph_q <= !ph_q;
          if (ph_q) st_q <= SQ_SHIFT;
        end
        SQ_SHIFT: if (tick_i) begin
          ph_q   <= !ph_q;
          sclk_q <= !ph_q;
          if (ph_q) begin
            if (k_q == total - 10'd1) st_q <= SQ_TRAIL;
            else                      k_q  <= k_q + 10'd1;
          end
        end
        SQ_TRAIL: if (tick_i) begin
          ph_q <= !ph_q;
          if (ph_q) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mosi_o = 1'b0;
    if (st_q == SQ_LEAD || st_q == SQ_SHIFT) begin
      if (k_q < 10'd8)         mosi_o = opcode_i[3'd7 - k_q[2:0]];
      else if (k_q < addr_end) mosi_o = address_i[aidx];
      else if (k_q < dum_end)  mosi_o = 1'b0;
      else                     mosi_o = dir_tx_i & tx_byte_i[3'd7 - dk[2:0]];
    end
  end

  assign busy_o    = (st_q != SQ_IDLE);
  assign sclk_o    = sclk_q;
  assign cap_we_o  = (st_q == SQ_SHIFT) && tick_i && !ph_q && in_data && !dir_tx_i;
  assign cap_idx_o = dk[8:3];
  assign cap_bit_o = 3'd7 - dk[2:0];
  assign cap_val_o = miso_i;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(busy_o && (cs_sel_i == 1'(g)));
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_wr_i,
  input  logic [6:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic [1:0] cs_n_o
);
  logic        busy_w, start_w, tick_w, dir_tx_w, cs_sel_w;
  logic [7:0]  opcode_w, tx_byte_w;
  logic [31:0] address_w;
  logic [2:0]  abytes_w, cap_bit_w;
  logic [4:0]  dummy_w;
  logic [6:0]  count_w;
  logic [5:0]  tx_idx_w, cap_idx_w;
  logic        cap_we_w, cap_val_w;

  spi_eng_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .busy_i(busy_w), .start_o(start_w),
    .opcode_o(opcode_w), .address_o(address_w), .abytes_o(abytes_w), .dummy_o(dummy_w),
    .count_o(count_w), .dir_tx_o(dir_tx_w), .cs_sel_o(cs_sel_w),
    .tx_idx_i(tx_idx_w), .tx_byte_o(tx_byte_w),
    .cap_we_i(cap_we_w), .cap_idx_i(cap_idx_w), .cap_bit_i(cap_bit_w), .cap_val_i(cap_val_w)
  );

  spi_eng_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_w), .tick_o(tick_w)
  );

  spi_eng_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .start_i(start_w),
    .opcode_i(opcode_w), .address_i(address_w), .abytes_i(abytes_w), .dummy_i(dummy_w),
    .count_i(count_w), .dir_tx_i(dir_tx_w), .cs_sel_i(cs_sel_w), .tx_byte_i(tx_byte_w),
    .miso_i(miso_i), .busy_o(busy_w), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
    .tx_idx_o(tx_idx_w), .cap_we_o(cap_we_w), .cap_idx_o(cap_idx_w),
    .cap_bit_o(cap_bit_w), .cap_val_o(cap_val_w)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic [1:0] cs_n_o,
  input logic       busy
);
  AST_CS_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1); // R6
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o == 2'b11) |-> !sclk_o); // R5
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R5
  AST_CS_STEADY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(cs_n_o)); // R6
endmodule

module spi_eng_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic [1:0]  auto_q,
  input logic [1:0]  unl_q,
  input logic [7:0]  opc_q,
  input logic [31:0] cfg_q
);
  AST_CLEAR_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(auto_q) & ~auto_q) != 2'b00) |-> ($past(unl_q) == 2'd2)); // R11
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> ($stable(opc_q) && $stable(cfg_q))); // R9
  AST_START_ONLY_MANUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(auto_q) == 2'b00)); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .mosi_o(mosi_o),
  .cs_n_o(cs_n_o), .busy(busy_w)
);

bind spi_eng_regs spi_eng_regs_chk u_regs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .auto_q(auto_q),
  .unl_q(unl_q), .opc_q(opc_q), .cfg_q(cfg_q)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb_top;
  localparam int HALF = 2;
  localparam int TCLK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sclk, mosi, miso = 1'b0;
  logic [1:0] cs_n;

  int n_tests = 0, n_fail = 0;
  int rise_n = 0, cs_falls = 0;
  logic obits [0:1023];
  logic [1:0] cs_seen;
  time t_fall, t_first, t_lastfall, t_rise;
  logic [31:0] rx_seed = 32'h1234_5678;
  logic [7:0] tb_buf [0:63];

  always #(TCLK/2) clk = ~clk;

  spi_cmd_engine #(.HALF_DIV(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  function automatic logic rx_bit(int n);
    return rx_seed[n % 32] ^ ((n / 32) % 2 == 1);
  endfunction

  // flash model
  always @(posedge sclk) begin
    if (rise_n < 1024) obits[rise_n] = mosi;
    if (rise_n == 0) begin t_first = $time; cs_seen = cs_n; end
    rise_n++;
  end
  always @(negedge sclk) begin t_lastfall = $time; miso = rx_bit(rise_n); end
  always @(negedge cs_n[0] or negedge cs_n[1]) begin t_fall = $time; cs_falls++; miso = rx_bit(0); end
  always @(posedge cs_n[0] or posedge cs_n[1]) t_rise = $time;

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [6:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [6:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic exp_bit(int k, logic [7:0] op, int na, int nd, logic [31:0] adr, logic dir);
    int j;
    if (k < 8) return op[7-k];
    if (k < 8 + 8*na) begin j = 8*na - 1 - (k - 8); return adr[j]; end
    if (k < 8 + 8*na + nd) return 1'b0;
    j = k - (8 + 8*na + nd);
    return dir ? tb_buf[j/8][7 - (j%8)] : 1'b0;
  endfunction

  task automatic run_txn(logic [7:0] op, int abr, int dmy, int cnt, logic dir, logic cs,
                         logic [31:0] adr, bit disturb);
    int na, nn, total, bad, guard;
    logic [7:0] d;
    na = (abr > 4) ? 4 : abr;
    nn = (cnt > 64) ? 64 : cnt;
    total = 8 + 8*na + dmy + 8*nn;
    bus_write(7'h02, {5'(dmy), 3'(abr)});
    bus_write(7'h03, {7'b0, cs});
    bus_write(7'h05, op);
    bus_write(7'h06, 8'(cnt));
    for (int b = 0; b < 4; b++) bus_write(7'(8 + b), adr[8*b +: 8]);
    if (dir) for (int b = 0; b < nn; b++) begin
      tb_buf[b] = 8'($urandom);
      bus_write(7'(64 + b), tb_buf[b]);
    end
    rx_seed = $urandom;
    rise_n = 0; cs_falls = 0;
    bus_write(7'h04, {4'b0000, dir, 3'b001});
    bus_read(7'h04, d);
    chk("R3 busy after start", d[1:0], 2'b10);
    if (disturb) begin
      bus_write(7'h05, ~op);
      bus_write(7'h04, {4'b0000, dir, 3'b001});
      bus_write(7'h40, ~tb_buf[0]);
      bus_write(7'h02, ~{5'(dmy), 3'(abr)});
    end
    guard = 0;
    do begin bus_read(7'h04, d); guard++; end while (d[1] && guard < 20000);
    chk("R3 busy clears", d[1], 0);
    chk("R4 sclk pulse count", rise_n, total);
    bad = -1;
    for (int k = 0; k < total && k < 1024; k++)
      if (bad < 0 && obits[k] !== exp_bit(k, op, na, dmy, adr, dir)) bad = k;
    chk("R4 R7 mosi stream first mismatch", bad, -1);
    chk("R6 chip select choice", cs_seen, cs ? 2'b01 : 2'b10);
    chk("R6 lead time", longint'(t_first - t_fall), 3*HALF*TCLK);
    chk("R6 trail time", longint'(t_rise - t_lastfall), 2*HALF*TCLK);
    if (!dir && nn > 0) begin
      bad = -1;
      for (int b = 0; b < nn; b++) begin
        logic [7:0] e;
        for (int i = 0; i < 8; i++) e[7-i] = rx_bit(8 + 8*na + dmy + 8*b + i);
        bus_read(7'(64 + b), d);
        if (bad < 0 && d !== e) bad = b;
      end
      chk("R8 received bytes first mismatch", bad, -1);
    end
    if (disturb) begin
      chk("R9 single transaction", cs_falls, 1);
      bus_read(7'h05, d); chk("R9 opcode kept", d, op);
      bus_read(7'h40, d); chk("R9 window kept", d, tb_buf[0]);
      bus_read(7'h02, d); chk("R9 config kept", d, {5'(dmy), 3'(abr)});
    end
  endtask

  task automatic unlock();
    bus_write(7'h05, 8'h55);
    bus_write(7'h05, 8'hAA);
  endtask

  initial begin
    #(200000 * TCLK);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk("R1 cs high in reset", cs_n, 2'b11);
    rst_n = 1'b1;
    bus_read(7'h04, d); chk("R1 control reset", d, 8'h30);
    bus_read(7'h05, d); chk("R1 opcode reset", d, 0);
    bus_read(7'h02, d); chk("R1 config reset", d, 0);
    bus_read(7'h0B, d); chk("R1 address reset", d, 0);
    chk("R1 cs and sclk idle", {cs_n, sclk}, 3'b110);

    bus_write(7'h00, 8'hA5); bus_read(7'h00, d); chk("R2 config byte0", d, 8'hA5);
    bus_write(7'h09, 8'h3C); bus_read(7'h09, d); chk("R2 address byte1", d, 8'h3C);
    bus_write(7'h7F, 8'h5A); bus_read(7'h7F, d); chk("R2 window last", d, 8'h5A);
    bus_read(7'h07, d); chk("R2 unmapped reads 0", d, 0);
    bus_write(7'h06, 8'h21); bus_read(7'h06, d); chk("R2 count", d, 8'h21);

    cs_falls = 0;
    bus_write(7'h04, 8'h31);
    repeat (40) @(negedge clk);
    chk("R10 no cs in auto", cs_falls, 0);
    bus_read(7'h04, d); chk("R10 still idle auto", d, 8'h30);

    bus_write(7'h04, 8'h00); bus_read(7'h04, d); chk("R11 clear refused", d[5:4], 2'b11);
    bus_write(7'h05, 8'h55); bus_write(7'h06, 8'h00); bus_write(7'h05, 8'hAA);
    bus_write(7'h04, 8'h00); bus_read(7'h04, d); chk("R11 broken pair refused", d[5:4], 2'b11);
    unlock(); bus_write(7'h04, 8'h00); bus_read(7'h04, d); chk("R11 unlock clears", d, 8'h00);
    bus_write(7'h04, 8'h20); bus_read(7'h04, d); chk("R11 set accepted", d, 8'h20);
    bus_write(7'h04, 8'h00); bus_read(7'h04, d); chk("R11 relock refuses clear", d[5:4], 2'b10);
    unlock(); bus_write(7'h04, 8'h00); bus_read(7'h04, d); chk("R11 manual again", d[5:4], 2'b00);

    run_txn(8'h0B, 3, 8, 16, 1'b0, 1'b0, 32'h0012_3456, 0);   // fast read
    run_txn(8'hE9, 0, 0, 0, 1'b1, 1'b1, 32'h0, 0);            // R7 count 0
    run_txn(8'h02, 3, 0, 64, 1'b1, 1'b1, 32'h00AB_CDEF, 0);   // full window
    run_txn(8'h12, 7, 3, 200, 1'b1, 1'b0, 32'h89AB_CDEF, 0);  // clamps
    run_txn(8'h32, 2, 1, 20, 1'b1, 1'b0, 32'h0000_4321, 1);   // R9 disturb
    for (int t = 0; t < 8; t++)
      run_txn(8'($urandom), int'($urandom % 5), int'($urandom % 32), int'($urandom % 66),
              1'($urandom), 1'($urandom), $urandom, 0);

    bus_write(7'h04, 8'h30);
    cs_falls = 0;
    bus_write(7'h04, 8'h39);
    repeat (40) @(negedge clk);
    chk("R10 auto start ignored", cs_falls, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule